// File: doc/BRIEF.md
# Banked RAM Expansion Mapper

This block pages extra RAM into the 64K address space of an 8-bit CPU. It watches the CPU bus for I/O writes aimed at the RAM-configuration port and keeps the configuration byte they carry. It then translates every CPU address into a physical block address. The CPU space is cut into four 16K windows, and each window shows either a base RAM block or a block of a selected 64K expansion bank.

The port is decoded from the upper address byte only. The lower address byte is free, so software may place any value there, including the data byte itself. Four further upper-byte codes reach banks beyond the 2MB point. The bus strobes are active low.

None of the interfaces carries a stream. Every pin is a plain control or data level, so there is no valid/ready handshake and no back-pressure. Address translation is combinational and follows the CPU address in the same cycle.

Top module: `ram_bank_mapper`

## Requirements
- R1: A configuration write is a cycle with iorq_n=0, wr_n=0 and mreq_n=1 whose upper address byte is 0x7F or one of 0x78..0x7B. The lower address byte has no effect on whether the write is accepted or on what it stores.
- R2: A configuration write is accepted only when data bits 7:6 are 2'b11. Any other data value leaves the mapping unchanged.
- R3: No cycle changes the mapping if it has mreq_n=0, wr_n=1, or an upper address byte outside the accepted codes (for example 0x7C..0x7E or 0xBF).
- R4: The new configuration is stored on the first clock edge at which the write strobe is seen released (wr_n or iorq_n high). While the strobe is held, the old mapping stays visible. The new mapping applies from the next cycle.
- R5: Reset (rst_n=0) selects mode 0 and bank 0, so every window shows the base block with the same index as the window.
- R6: Data bits 2:0 select the mode. The mapping for windows 0..3 (selected by CPU A15:14) is:
  - mode 0: B0 B1 B2 B3
  - mode 1: B0 B1 B2 E3
  - mode 2: E0 E1 E2 E3
  - mode 3: B0 B3 B2 E3

  Here Bn is base block n and En is block n of the selected expansion bank.
- R7: Modes 4..7 map window 1 to expansion block (mode-4). Windows 0, 2 and 3 show base blocks 0, 2 and 3.
- R8: The bank number is 6 bits. Its low 3 bits are data bits 5:3. Its high 3 bits are the inverted upper address bits A10:A8, so 0x7F gives 000, 0x7B gives 100 and 0x78 gives 111.
- R9: phys_addr is {bank[5:0], block[1:0], A13:0}, and phys_exp=1 marks an expansion block. For a base block the bank field is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cpu_addr | input | 16 | CPU address A15..A0 |
| cpu_data | input | 8 | CPU data D7..D0 |
| iorq_n | input | 1 | I/O request strobe, active low |
| mreq_n | input | 1 | Memory request strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| phys_addr | output | 22 | Translated physical address {bank, block, offset} |
| phys_exp | output | 1 | 1 when the address lies in expansion RAM |

## Verification
The hardest situation to reach from the ports is the interval while a configuration write is still held. In that interval the port has captured the new byte, but the mapping must still be the old one. The stimulus holds both strobes across a clock edge, using an address that falls in window 1, and samples the translated output before and after the release.

The second difficult case is aliasing. The same mode is written through the 0x78..0x7B codes and through 0x7F with different low bytes, so the bank extension and the ignored low byte both show up in phys_addr.

// File: rtl/rbm_pkg.sv
package rbm_pkg;
  localparam int CPU_AW  = 16;
  localparam int OFS_W   = 14;
  localparam int BLK_W   = CPU_AW - OFS_W;
  localparam int NWIN    = 1 << BLK_W;
  localparam int MODE_W  = 3;
  localparam int DBANK_W = 3;
  localparam int EXT_W   = 3;
  localparam int BANK_W  = DBANK_W + EXT_W;
  localparam int PA_W    = BANK_W + BLK_W + OFS_W;

  typedef struct packed {
    logic [MODE_W-1:0] mode;
    logic [BANK_W-1:0] bank;
  } cfg_t;

  typedef struct packed {
    logic             exp;
    logic [BLK_W-1:0] blk;
  } slot_t;

  // Which block a given window shows in a given mode
  function automatic slot_t slot_for(input logic [MODE_W-1:0] mode, input int win);
    slot_t s;
    s.exp = 1'b0;
    s.blk = BLK_W'(win);
    case (mode)
      3'd0: ;
      3'd1: if (win == 3) s.exp = 1'b1;
      3'd2: s.exp = 1'b1;
      3'd3: begin
        if (win == 1) s.blk = BLK_W'(3);
        else if (win == 3) s.exp = 1'b1;
      end
      default: if (win == 1) begin
        s.exp = 1'b1;
        s.blk = mode[BLK_W-1:0];
      end
    endcase
    return s;
  endfunction
endpackage

// File: rtl/rbm_cfg_port.sv
module rbm_cfg_port
  import rbm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] addr_hi,
  input  logic [7:0] data,
  input  logic       iorq_n,
  input  logic       mreq_n,
  input  logic       wr_n,
  output cfg_t       cfg
);
  logic hit, qual, pend;
  cfg_t cap, incoming;

  assign hit  = (addr_hi == 8'h7F) || (addr_hi[7:2] == 6'b011110);
  assign qual = !iorq_n && !wr_n && mreq_n && hit && (data[7:6] == 2'b11);

  assign incoming.mode = data[MODE_W-1:0];
  assign incoming.bank = {~addr_hi[EXT_W-1:0], data[MODE_W +: DBANK_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      cap  <= '0;
      cfg  <= '0;
    end else if (qual) begin
      pend <= 1'b1;
      cap  <= incoming;
    end else if (pend && (wr_n || iorq_n)) begin
      pend <= 1'b0;
      cfg  <= cap;
    end
  end
endmodule

// File: rtl/rbm_window_map.sv
module rbm_window_map
  import rbm_pkg::*;
(
  input  cfg_t              cfg,
  input  logic [CPU_AW-1:0] cpu_addr,
  output logic [PA_W-1:0]   phys_addr,
  output logic              phys_exp
);
  slot_t tbl [NWIN];
  slot_t sel;

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    assign tbl[w] = slot_for(cfg.mode, w);
  end

  assign sel       = tbl[cpu_addr[CPU_AW-1:OFS_W]];
  assign phys_exp  = sel.exp;
  assign phys_addr = {sel.exp ? cfg.bank : {BANK_W{1'b0}}, sel.blk, cpu_addr[OFS_W-1:0]};
endmodule

// File: rtl/ram_bank_mapper.sv
module ram_bank_mapper
  import rbm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [7:0]        cpu_data,
  input  logic              iorq_n,
  input  logic              mreq_n,
  input  logic              wr_n,
  output logic [PA_W-1:0]   phys_addr,
  output logic              phys_exp
);
  cfg_t cfg;

  rbm_cfg_port i_port (
    .clk     (clk),
    .rst_n   (rst_n),
    .addr_hi (cpu_addr[CPU_AW-1 -: 8]),
    .data    (cpu_data),
    .iorq_n  (iorq_n),
    .mreq_n  (mreq_n),
    .wr_n    (wr_n),
    .cfg     (cfg)
  );

  rbm_window_map i_map (
    .cfg       (cfg),
    .cpu_addr  (cpu_addr),
    .phys_addr (phys_addr),
    .phys_exp  (phys_exp)
  );
endmodule

// File: rtl/rbm_checker.sv
module rbm_checker
  import rbm_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [CPU_AW-1:0] cpu_addr,
  input logic [7:0]        cpu_data,
  input logic              iorq_n,
  input logic              mreq_n,
  input logic              wr_n,
  input logic [PA_W-1:0]   phys_addr,
  input logic              phys_exp,
  input cfg_t              cfg
);
  logic port_wr;
  assign port_wr = !iorq_n && !wr_n && mreq_n &&
                   ((cpu_addr[15:8] == 8'h7F) || (cpu_addr[15:10] == 6'b011110));

  // R1
  cfg_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $past(port_wr, 2));

  // R2
  data_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> ($past(cpu_data[7:6], 2) == 2'b11));

  // R4
  commit_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cfg) |-> $past(wr_n || iorq_n));

  // R5
  reset_cfg_chk: assert property (@(posedge clk)
    !rst_n |=> (cfg == '0));

  // R6
  window0_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[15:14] == 2'd0 && cfg.mode != 3'd2) |-> (!phys_exp && phys_addr[15:14] == 2'd0));

  // R9
  base_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !phys_exp |-> (phys_addr[PA_W-1 -: BANK_W] == '0));
endmodule

bind ram_bank_mapper rbm_checker i_rbm_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_addr  (cpu_addr),
  .cpu_data  (cpu_data),
  .iorq_n    (iorq_n),
  .mreq_n    (mreq_n),
  .wr_n      (wr_n),
  .phys_addr (phys_addr),
  .phys_exp  (phys_exp),
  .cfg       (cfg)
);

// File: tb/test_ram_bank_mapper.sv
module test_ram_bank_mapper;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = 16'h0000;
  logic [7:0]  cpu_data = 8'h00;
  logic        iorq_n = 1'b1, mreq_n = 1'b1, wr_n = 1'b1;
  logic [21:0] phys_addr;
  logic        phys_exp;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  logic [2:0]  m_mode = 3'd0;
  logic [5:0]  m_bank = 6'd0;
  logic [22:0] q_exp [$];
  string       q_req [$];

  always #2 clk = ~clk;

  ram_bank_mapper i_ram_bank_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_data(cpu_data),
    .iorq_n(iorq_n), .mreq_n(mreq_n), .wr_n(wr_n),
    .phys_addr(phys_addr), .phys_exp(phys_exp)
  );

  function automatic logic [22:0] predict(input logic [15:0] a);
    logic       e;
    logic [1:0] b;
    logic [1:0] w;
    w = a[15:14];
    e = 1'b0;
    b = w;
    case (m_mode)
      3'd0: ;
      3'd1: e = (w == 2'd3);
      3'd2: e = 1'b1;
      3'd3: begin
        if (w == 2'd1) b = 2'd3;
        e = (w == 2'd3);
      end
      default: if (w == 2'd1) begin
        e = 1'b1;
        b = 2'(m_mode - 3'd4);
      end
    endcase
    return {e, (e ? m_bank : 6'd0), b, a[13:0]};
  endfunction

  task automatic check(input logic [22:0] got, input logic [22:0] exp, input string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got exp=%0b addr=%h, expected exp=%0b addr=%h",
               req, got[22], got[21:0], exp[22], exp[21:0]);
    end
  endtask

  task automatic mem(input logic [15:0] a, input string req);
    @(negedge clk);
    cpu_addr = a;
    mreq_n   = 1'b0;
    q_exp.push_back(predict(a));
    q_req.push_back(req);
    @(negedge clk);
    mreq_n = 1'b1;
  endtask

  task automatic bus_io(input logic [15:0] a, input logic [7:0] d,
                        input bit with_mreq, input bit is_wr);
    @(negedge clk);
    cpu_addr = a;
    cpu_data = d;
    iorq_n   = 1'b0;
    wr_n     = !is_wr;
    mreq_n   = !with_mreq;
    @(negedge clk);
    iorq_n = 1'b1;
    wr_n   = 1'b1;
    mreq_n = 1'b1;
    @(negedge clk);
    if (!with_mreq && is_wr && d[7:6] == 2'b11 &&
        (a[15:8] == 8'h7F || a[15:10] == 6'b011110)) begin
      m_mode = d[2:0];
      m_bank = {~a[10:8], d[5:3]};
    end
  endtask

  task automatic all_windows(input string req);
    mem(16'h0123, req);
    mem(16'h5103, req);
    mem(16'hA5A5, req);
    mem(16'hFFFF, req);
  endtask

  // Scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (!mreq_n && q_exp.size() > 0) begin
        check({phys_exp, phys_addr}, q_exp.pop_front(), q_req.pop_front());
      end
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: got hang, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    all_windows("R5 reset base map");

    bus_io(16'h7FC1, 8'hC1, 0, 1);
    all_windows("R6 mode1");

    bus_io(16'h7F00, 8'hC2, 0, 1);
    all_windows("R1 R6 mode2 low byte 00");

    bus_io(16'h7FFF, 8'hC3, 0, 1);
    all_windows("R1 R6 mode3 low byte FF");

    // R4: hold a write to 0x7FC4 across an edge, old mapping stays
    @(negedge clk);
    cpu_addr = 16'h7FC4;
    cpu_data = 8'hC4;
    iorq_n   = 1'b0;
    wr_n     = 1'b0;
    @(negedge clk);
    check({phys_exp, phys_addr}, predict(16'h7FC4), "R4 held strobe keeps old map");
    iorq_n = 1'b1;
    wr_n   = 1'b1;
    m_mode = 3'd4;
    m_bank = 6'd0;
    @(negedge clk);
    check({phys_exp, phys_addr}, predict(16'h7FC4), "R4 map after release");
    check({phys_exp, phys_addr}, {1'b1, 6'd0, 2'd0, 14'h3FC4}, "R7 C4 block0 in window1");

    bus_io(16'h7F12, 8'hC5, 0, 1);
    mem(16'h5103, "R7 C5 block1 at 0x5103");
    check({1'b1, 6'd0, 2'd1, 14'h1103}, predict(16'h5103), "R9 address layout");
    all_windows("R7 mode5");

    bus_io(16'h7F00, 8'hEE, 0, 1);
    all_windows("R8 R7 mode6 bank5");

    bus_io(16'h7900, 8'hCC, 0, 1);
    all_windows("R8 code 0x79 bank 0x31");

    bus_io(16'h7B00, 8'hC2, 0, 1);
    all_windows("R8 code 0x7B bank 0x20");

    bus_io(16'h7800, 8'hFF, 0, 1);
    all_windows("R8 code 0x78 bank 0x3F");

    bus_io(16'h7E00, 8'hC0, 0, 1);
    all_windows("R3 upper 0x7E ignored");
    bus_io(16'hBF00, 8'hC0, 0, 1);
    all_windows("R3 upper 0xBF ignored");
    bus_io(16'h7FC0, 8'hC0, 1, 1);
    all_windows("R3 mreq low ignored");
    bus_io(16'h7FC0, 8'hC0, 0, 0);
    all_windows("R3 read cycle ignored");
    bus_io(16'h7F00, 8'h89, 0, 1);
    all_windows("R2 data tag not 11 ignored");

    bus_io(16'h7FC0, 8'hC0, 0, 1);
    all_windows("R6 back to mode0");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule